// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a field-configurable logic array. A bank of AND gates forms product terms from the external inputs and from the fed-back output flip-flops. A bank of OR gates then merges selected terms into each output. Every connection is a stored bit. A blank (erased) map connects everything, and loading a map removes the links that are not wanted. Each output can drive its OR result straight to the pin or through a flip-flop clocked by the block clock.

A single-bit serial port configures the block. One command erases the whole map. A second shifts a new map in, one bit per clock. A third rotates the map out for inspection and leaves the map unchanged after a full pass. A mode input switches the OR bank to a fixed wiring: each output then uses only its own pair of terms.

Top module: `pla_core`

## Requirements
- R1: A clock with `cfg_erase` high sets every AND-bank and OR-bank bit to 1 and every register-select bit to 0. With the erased map every output reads 0.
- R2: Each term has 40 columns. Column 2i is input i true and column 2i+1 is input i inverted, for i = 0 to 11. Column 24+2j is output flip-flop j true and column 25+2j is its inverse. A term is the AND of the literals whose bit is 1. A term with no bit set reads 1, and a term holding a literal and its inverse reads 0.
- R3: Outside fixed mode, output k is the OR of the terms t whose OR bit (k,t) is 1. Several outputs may share a term, and an output with no OR bits set reads 0.
- R4: When the register-select bit of output k is 1, the pin shows the OR result captured at the previous rising clock edge. When it is 0, the pin follows the OR result in the same cycle.
- R5: The AND bank always takes output j from its flip-flop, whatever the register-select bit of output j.
- R6: While `pal_mode` is 1, output k is the OR of terms 2k and 2k+1 only, and the OR-bank bits have no effect on any output.
- R7: While `cfg_shift` is high, each clock shifts `cfg_din` into the map. Map bit n is the n-th bit loaded, counting from 0 over 776 bits. Bits 0 to 639 are the AND bank at index term*40+column. Bits 640 to 767 are the OR bank at 640+output*16+term. Bits 768 to 775 are the register selects, one per output.
- R8: While erase, shift or read is active, all outputs read 0 and the output flip-flops are cleared. Erase has priority over shift, and shift has priority over read.
- R9: While `cfg_read` is high, `cfg_dout` shows map bit n after n clocks of reading. After 776 clocks the map is back to its original content.
- R10: A clock with `rst` high clears every output flip-flop and leaves the map unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset of the output flip-flops |
| in_pins | input | 12 | External logic inputs |
| pal_mode | input | 1 | 1 selects fixed OR wiring, two terms per output |
| cfg_erase | input | 1 | Erase the connection map |
| cfg_shift | input | 1 | Shift `cfg_din` into the map |
| cfg_read | input | 1 | Rotate the map out on `cfg_dout` |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial read-back data out |
| out_pins | output | 8 | Array outputs |

## Verification
The bench builds the block with its default sizes: 12 inputs, 8 outputs and 16 terms, which gives a 776-bit map. At these sizes a full load and a full read-back take under a thousand clocks, so the bench can load several maps and read each one back. One map exercises, side by side, an empty term, a self-contradicting term, a shared term, a registered output and a feedback term. The fixed-OR mode is run with the same AND bank under two different OR banks, to show that the OR bits have no effect in that mode.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int DEF_N_IN   = 12;
  localparam int DEF_N_OUT  = 8;
  localparam int DEF_N_TERM = 16;

  typedef enum logic [1:0] {
    OP_RUN   = 2'd0,
    OP_ERASE = 2'd1,
    OP_LOAD  = 2'd2,
    OP_READ  = 2'd3
  } cfg_op_e;

  // Erase outranks shift, which outranks read.
  function automatic cfg_op_e decode_op(input logic erase, input logic shift, input logic read);
    if (erase) return OP_ERASE;
    if (shift) return OP_LOAD;
    if (read)  return OP_READ;
    return OP_RUN;
  endfunction
endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int AND_BITS = 640,
  parameter int OR_BITS  = 128,
  parameter int N_OUT    = 8,
  localparam int MAP_BITS = AND_BITS + OR_BITS + N_OUT
) (
  input  logic                 clk,
  input  pla_pkg::cfg_op_e     op,
  input  logic                 din,
  output logic [MAP_BITS-1:0]  map_q,
  output logic                 dout
);
  localparam logic [MAP_BITS-1:0] ERASED = {{N_OUT{1'b0}}, {(AND_BITS+OR_BITS){1'b1}}};

  always_ff @(posedge clk) begin
    case (op)
      pla_pkg::OP_ERASE: map_q <= ERASED;
      pla_pkg::OP_LOAD:  map_q <= {din, map_q[MAP_BITS-1:1]};
      pla_pkg::OP_READ:  map_q <= {map_q[0], map_q[MAP_BITS-1:1]};
      default:           map_q <= map_q;
    endcase
  end

  assign dout = map_q[0];
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN   = 12,
  parameter int N_OUT  = 8,
  parameter int N_TERM = 16,
  localparam int N_COL = 2 * (N_IN + N_OUT)
) (
  input  logic [N_IN-1:0]         ext_in,
  input  logic [N_OUT-1:0]        fb,
  input  logic [N_TERM*N_COL-1:0] and_map,
  output logic [N_TERM-1:0]       terms
);
  function automatic logic [N_COL-1:0] literals(input logic [N_IN-1:0] x, input logic [N_OUT-1:0] q);
    logic [N_COL-1:0] l;
    for (int i = 0; i < N_IN; i++) begin
      l[2*i]   = x[i];
      l[2*i+1] = ~x[i];
    end
    for (int j = 0; j < N_OUT; j++) begin
      l[2*N_IN+2*j]   = q[j];
      l[2*N_IN+2*j+1] = ~q[j];
    end
    return l;
  endfunction

  // An unconnected column contributes a 1 to the AND.
  function automatic logic term_hit(input logic [N_COL-1:0] lits, input logic [N_COL-1:0] conn);
    return &(lits | ~conn);
  endfunction

  logic [N_COL-1:0] lit_w;
  assign lit_w = literals(ext_in, fb);

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    assign terms[t] = term_hit(lit_w, and_map[t*N_COL +: N_COL]);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_OUT  = 8,
  parameter int N_TERM = 16,
  localparam int TPO = N_TERM / N_OUT
) (
  input  logic                    pal_mode,
  input  logic [N_TERM-1:0]       terms,
  input  logic [N_OUT*N_TERM-1:0] or_map,
  output logic [N_OUT-1:0]        sums
);
  function automatic logic [N_TERM-1:0] fixed_mask(input int k);
    logic [N_TERM-1:0] m;
    m = '0;
    for (int b = 0; b < TPO; b++) m[k*TPO+b] = 1'b1;
    return m;
  endfunction

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic [N_TERM-1:0] sel;
    assign sel     = pal_mode ? fixed_mask(k) : or_map[k*N_TERM +: N_TERM];
    assign sums[k] = |(terms & sel);
  end
endmodule

// File: rtl/pla_core.sv
module pla_core #(
  parameter int N_IN   = pla_pkg::DEF_N_IN,
  parameter int N_OUT  = pla_pkg::DEF_N_OUT,
  parameter int N_TERM = pla_pkg::DEF_N_TERM
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IN-1:0]  in_pins,
  input  logic             pal_mode,
  input  logic             cfg_erase,
  input  logic             cfg_shift,
  input  logic             cfg_read,
  input  logic             cfg_din,
  output logic             cfg_dout,
  output logic [N_OUT-1:0] out_pins
);
  localparam int N_COL    = 2 * (N_IN + N_OUT);
  localparam int AND_BITS = N_TERM * N_COL;
  localparam int OR_BITS  = N_OUT * N_TERM;
  localparam int MAP_BITS = AND_BITS + OR_BITS + N_OUT;

  pla_pkg::cfg_op_e      op;
  logic                  cfg_busy;
  logic [MAP_BITS-1:0]   map_q;
  logic [N_TERM-1:0]     terms;
  logic [N_OUT-1:0]      sums;
  logic [N_OUT-1:0]      q_r;
  logic [N_OUT-1:0]      reg_sel;

  assign op       = pla_pkg::decode_op(cfg_erase, cfg_shift, cfg_read);
  assign cfg_busy = (op != pla_pkg::OP_RUN);
  assign reg_sel  = map_q[AND_BITS+OR_BITS +: N_OUT];

  pla_cfg_chain #(.AND_BITS(AND_BITS), .OR_BITS(OR_BITS), .N_OUT(N_OUT)) u_chain (
    .clk(clk), .op(op), .din(cfg_din), .map_q(map_q), .dout(cfg_dout)
  );

  pla_and_plane #(.N_IN(N_IN), .N_OUT(N_OUT), .N_TERM(N_TERM)) u_and (
    .ext_in(in_pins), .fb(q_r), .and_map(map_q[AND_BITS-1:0]), .terms(terms)
  );

  pla_or_plane #(.N_OUT(N_OUT), .N_TERM(N_TERM)) u_or (
    .pal_mode(pal_mode), .terms(terms), .or_map(map_q[AND_BITS +: OR_BITS]), .sums(sums)
  );

  // Every output keeps a flip-flop; it feeds the AND bank even when bypassed.
  always_ff @(posedge clk) begin
    if (rst || cfg_busy) q_r <= '0;
    else                 q_r <= sums;
  end

  assign out_pins = cfg_busy ? '0 : ((reg_sel & q_r) | (~reg_sel & sums));
endmodule

// File: rtl/pla_core_chk.sv
module pla_core_chk #(
  parameter int MAP_BITS = 776,
  parameter int AND_BITS = 640,
  parameter int OR_BITS  = 128,
  parameter int N_OUT    = 8
) (
  input logic                clk,
  input logic                rst,
  input pla_pkg::cfg_op_e    cfg_op,
  input logic                cfg_busy,
  input logic                cfg_din,
  input logic                cfg_dout,
  input logic [MAP_BITS-1:0] map_q,
  input logic [N_OUT-1:0]    q_r,
  input logic [N_OUT-1:0]    sums,
  input logic [N_OUT-1:0]    out_pins
);
  logic clr_d = 1'b0;

  always_ff @(posedge clk) begin
    if (clr_d) begin
      assert_flop_clear_R10: assert (q_r == '0) else $error("flip-flops not cleared");
    end
    clr_d <= rst || cfg_busy;
  end

  assert_busy_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_busy |-> (out_pins == '0));

  assert_erase_map_R1: assert property (@(posedge clk) disable iff (rst)
    (cfg_op == pla_pkg::OP_ERASE) |=>
      ((&map_q[AND_BITS+OR_BITS-1:0]) && (map_q[MAP_BITS-1 -: N_OUT] == '0)));

  assert_load_entry_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_op == pla_pkg::OP_LOAD) |=> (map_q[MAP_BITS-1] == $past(cfg_din)));

  assert_read_rotate_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_op == pla_pkg::OP_READ) |=>
      ((cfg_dout == $past(map_q[1])) && (map_q[MAP_BITS-1] == $past(cfg_dout))));

  assert_flop_track_R4: assert property (@(posedge clk) disable iff (rst)
    !cfg_busy |=> (q_r == $past(sums)));

  assert_map_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_op == pla_pkg::OP_RUN) |=> $stable(map_q));
endmodule

bind pla_core pla_core_chk #(
  .MAP_BITS(MAP_BITS), .AND_BITS(AND_BITS), .OR_BITS(OR_BITS), .N_OUT(N_OUT)
) u_chk (
  .clk(clk), .rst(rst), .cfg_op(op), .cfg_busy(cfg_busy), .cfg_din(cfg_din),
  .cfg_dout(cfg_dout), .map_q(map_q), .q_r(q_r), .sums(sums), .out_pins(out_pins)
);

// File: tb/pla_core_test.sv
module pla_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 12, NO = 8, NT = 16;
  localparam int NC = 2 * (NI + NO);
  localparam int NMAP = NT * NC + NO * NT + NO;

  logic clk = 0, rst = 1, pal_mode = 0;
  logic cfg_erase = 0, cfg_shift = 0, cfg_read = 0, cfg_din = 0;
  logic [NI-1:0] in_pins = '0;
  logic cfg_dout;
  logic [NO-1:0] out_pins;

  int n_tests = 0, n_fail = 0;

  pla_core uut (.clk(clk), .rst(rst), .in_pins(in_pins), .pal_mode(pal_mode),
    .cfg_erase(cfg_erase), .cfg_shift(cfg_shift), .cfg_read(cfg_read),
    .cfg_din(cfg_din), .cfg_dout(cfg_dout), .out_pins(out_pins));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference map and output flip-flop model
  bit and_m [NT][NC];
  bit or_m  [NO][NT];
  bit reg_m [NO];
  logic [NO-1:0] q_m = '0;

  function automatic bit mbit(int n);
    if (n < NT*NC) return and_m[n / NC][n % NC];
    if (n < NT*NC + NO*NT) return or_m[(n - NT*NC) / NT][(n - NT*NC) % NT];
    return reg_m[n - NT*NC - NO*NT];
  endfunction

  function automatic logic [NO-1:0] m_comb(logic [NI-1:0] x, logic [NO-1:0] q);
    logic [NT-1:0] tv;
    logic [NO-1:0] r;
    for (int t = 0; t < NT; t++) begin
      tv[t] = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (and_m[t][2*i] && !x[i]) tv[t] = 1'b0;
        if (and_m[t][2*i+1] && x[i]) tv[t] = 1'b0;
      end
      for (int j = 0; j < NO; j++) begin
        if (and_m[t][2*NI+2*j] && !q[j]) tv[t] = 1'b0;
        if (and_m[t][2*NI+2*j+1] && q[j]) tv[t] = 1'b0;
      end
    end
    r = '0;
    for (int k = 0; k < NO; k++)
      for (int t = 0; t < NT; t++)
        if (tv[t] && (pal_mode ? (t / (NT/NO) == k) : or_m[k][t])) r[k] = 1'b1;
    return r;
  endfunction

  function automatic logic [NO-1:0] m_out();
    logic [NO-1:0] c, o;
    if (cfg_erase || cfg_shift || cfg_read) return '0;
    c = m_comb(in_pins, q_m);
    for (int k = 0; k < NO; k++) o[k] = reg_m[k] ? q_m[k] : c[k];
    return o;
  endfunction

  always @(posedge clk) begin
    if (rst || cfg_erase || cfg_shift || cfg_read) q_m <= '0;
    else q_m <= m_comb(in_pins, q_m);
  end

  // Scoreboard
  typedef struct { logic [NO-1:0] exp; string tag; } item_t;
  item_t sb[$];

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_tests++;
      if (out_pins !== it.exp) begin
        n_fail++;
        $display("FAIL %s: out_pins actual=%b expected=%b", it.tag, out_pins, it.exp);
      end
    end
  end

  task automatic check_val(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive_check(logic [NI-1:0] x, string tag);
    item_t it;
    @(posedge clk); #1;
    in_pins = x;
    #1;
    it.exp = m_out();
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic erase_map();
    @(posedge clk); #1 cfg_erase = 1;
    @(posedge clk); #1 cfg_erase = 0;
    for (int t = 0; t < NT; t++) for (int c = 0; c < NC; c++) and_m[t][c] = 1;
    for (int k = 0; k < NO; k++) begin
      reg_m[k] = 0;
      for (int t = 0; t < NT; t++) or_m[k][t] = 1;
    end
  endtask

  task automatic load_map();
    @(posedge clk); #1 cfg_shift = 1;
    for (int n = 0; n < NMAP; n++) begin
      cfg_din = mbit(n);
      if (n == 100) begin
        @(negedge clk);
        check_val("R8 outputs zero while loading", int'(out_pins), 0);
      end
      @(posedge clk); #1;
    end
    cfg_shift = 0;
  endtask

  task automatic read_map(string tag);
    int bad = 0;
    @(posedge clk); #1 cfg_read = 1;
    for (int n = 0; n < NMAP; n++) begin
      @(negedge clk);
      if (cfg_dout !== mbit(n)) bad++;
      if (n == 5) check_val("R8 outputs zero while reading", int'(out_pins), 0);
      @(posedge clk);
    end
    #1 cfg_read = 0;
    check_val(tag, bad, 0);
  endtask

  task automatic clear_term(int t);
    for (int c = 0; c < NC; c++) and_m[t][c] = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    erase_map();
    drive_check(12'hFFF, "R1 erased map gives zeros");
    drive_check(12'h000, "R1 erased map gives zeros");
    read_map("R1 R9 erased map read-back");

    // Map A
    for (int k = 0; k < NO; k++) for (int t = 0; t < NT; t++) or_m[k][t] = 0;
    clear_term(0); and_m[0][0] = 1; and_m[0][2] = 1;   // in0 & in1
    clear_term(1); and_m[1][5] = 1;                    // ~in2
    clear_term(2);                                     // empty term
    clear_term(3); and_m[3][6] = 1;                    // in3
    clear_term(4); and_m[4][2*NI+8] = 1;               // flip-flop 4
    or_m[0][0] = 1; or_m[1][1] = 1; or_m[2][0] = 1; or_m[2][1] = 1;
    or_m[3][2] = 1; or_m[4][3] = 1; or_m[5][4] = 1; or_m[6][5] = 1;
    reg_m[4] = 1;
    load_map();
    read_map("R7 R9 loaded map read-back");

    drive_check(12'h004, "R2 R3 literals false, empty term true");
    drive_check(12'h003, "R2 R3 AND of in0 in1, shared term");
    drive_check(12'h00B, "R3 shared term both terms");
    drive_check(12'h001, "R2 partial match");
    drive_check(12'h008, "R4 registered output lags");
    drive_check(12'h008, "R4 R5 registered value and feedback");
    drive_check(12'h000, "R4 R5 registered value held one cycle");
    drive_check(12'h000, "R5 feedback cleared");
    drive_check(12'h008, "R4 rise again");
    drive_check(12'h008, "R5 feedback high");

    begin
      item_t it;
      @(posedge clk); #1 rst = 1;
      @(posedge clk); #1 rst = 0; #1;
      it.exp = m_out(); it.tag = "R10 reset clears flip-flops";
      sb.push_back(it);
      @(negedge clk); #1;
      check_val("R10 flop output after reset", int'(out_pins[4]), 0);
    end
    read_map("R10 map kept across reset");

    pal_mode = 1;
    drive_check(12'h003, "R6 fixed pairs");
    drive_check(12'h004, "R6 fixed pairs");
    drive_check(12'h007, "R6 fixed pairs");
    for (int k = 0; k < NO; k++) for (int t = 0; t < NT; t++) or_m[k][t] = 1;
    load_map();
    drive_check(12'h003, "R6 OR bits have no effect");
    drive_check(12'h004, "R6 OR bits have no effect");
    drive_check(12'h007, "R6 OR bits have no effect");
    pal_mode = 0;
    drive_check(12'h004, "R3 full OR plane");
    drive_check(12'h004, "R3 R4 full OR plane registered");

    repeat (2) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule